// File: doc/BRIEF.md
# Slot-Reserved Shared Memory Arbiter

This block shares one memory among three masters: a display fetch engine, a processor and an auxiliary DMA engine. Time is cut into memory slots, one per clock. Slots alternate strictly between a display slot and a free slot. The display engine may use every display slot, and no other master may ever take one, even when the display engine leaves it unused. Free slots are contested by the DMA engine and the processor, and the DMA engine always wins.

A processor access that arrives in a display slot is held off with a one-cycle wait. Its retry then falls into the following free slot. Because the processor issues at most one access every two clocks, it stays in step with the free slots once aligned. The display side can stretch the slot phase by one clock through a phase-hold input, to model its timing drifting against the processor. After such a shift the processor gets one more single-cycle wait and is back in step.

All grants, the processor wait and the memory address and strobe are decided combinationally from the current slot phase and the requests. Four free-running counters record display grants, processor grants, DMA grants and processor wait cycles. A test environment can use them to confirm the bandwidth split.

Top module: `slotArbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the slot is a display slot (`vidSlot`=1) and all four counters read 0.
- R2: With `resync` low the slot type toggles every clock. A cycle with `resync` high is followed by a cycle of the same slot type.
- R3: In a display slot a display request is always granted, together with its address on `memAddr` and `memStrobe`=1. In a free slot the display port is never granted.
- R4: In a display slot the processor and DMA ports are never granted. A display slot that the display port does not use stays idle (`memStrobe`=0) even if other requests are pending.
- R5: In a free slot a DMA request is granted. If the processor also requests, the processor is not granted and `cpuWait` is 1.
- R6: A processor request made in a display slot, with no DMA request and no phase hold, waits exactly one cycle and is granted in the next cycle.
- R7: `cpuWait` is 1 exactly in the cycles where `cpuReq` is 1 and `cpuGnt` is 0.
- R8: `memAddr` carries the address of the granted port and `memStrobe` is 1 when any port is granted. With no grant, `memStrobe` is 0 and `memAddr` is 0.
- R9: Each counter rises by one at the clock edge that ends a cycle with its event: a display grant, a processor grant, a DMA grant, or a processor wait cycle.
- R10: At most one port is granted in any cycle.
- R11: A processor that requests only in free slots, one request every two clocks, is granted each time and never waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one memory slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Hold the slot phase for one cycle (display drift) |
| vidReq | input | 1 | Display port request |
| vidAddr | input | ADDR_W | Display port address |
| vidGnt | output | 1 | Display port granted this cycle |
| cpuReq | input | 1 | Processor request, held until granted |
| cpuAddr | input | ADDR_W | Processor address |
| cpuGnt | output | 1 | Processor granted this cycle |
| cpuWait | output | 1 | Processor held this cycle |
| dmaReq | input | 1 | DMA port request |
| dmaAddr | input | ADDR_W | DMA port address |
| dmaGnt | output | 1 | DMA port granted this cycle |
| vidSlot | output | 1 | Current slot is a display slot |
| memAddr | output | ADDR_W | Address presented to memory |
| memStrobe | output | 1 | Memory access this cycle |
| vidCount | output | CNT_W | Display grants since reset |
| cpuCount | output | CNT_W | Processor grants since reset |
| dmaCount | output | CNT_W | DMA grants since reset |
| stallCount | output | CNT_W | Processor wait cycles since reset |

## Verification
Grants, `cpuWait`, `memAddr` and `memStrobe` settle in the same cycle as the requests. The bench drives inputs on the falling edge and reads these outputs one time unit before the next rising edge. The slot type and the counters change only at a rising edge, so they are read at the falling edge after the cycle that caused the change. The processor retry is checked one full cycle after the waited cycle, and a phase hold is checked as a repeated slot type in the cycle after `resync` was high. Before each scenario the bench aligns to the slot type it needs by reading `vidSlot`.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from the slot control to the datapath.
  typedef struct packed {
    logic selVid;
    logic selCpu;
    logic selDma;
    logic stall;
  } arbStrobe_t;

  localparam int NUM_CNT = 4;  // video, cpu, dma, stall
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resync,
  input  logic       vidReq,
  input  logic       cpuReq,
  input  logic       dmaReq,
  output logic       vidSlot,
  output logic       cpuWait,
  output arbStrobe_t strobe
);
  // Slot parity: 0 = display slot, 1 = free slot.
  logic phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else if (!resync) phase <= ~phase;
  end

  logic freeSlot;
  assign freeSlot = phase;
  assign vidSlot  = ~phase;

  always_comb begin
    strobe        = '0;
    strobe.selVid = vidReq & ~freeSlot;
    strobe.selDma = dmaReq & freeSlot;
    strobe.selCpu = cpuReq & freeSlot & ~dmaReq;
    strobe.stall  = cpuReq & ~strobe.selCpu;
  end

  assign cpuWait = strobe.stall;
endmodule

// File: rtl/arbPath.sv
module arbPath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  arbStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]           vidAddr,
  input  logic [ADDR_W-1:0]           cpuAddr,
  input  logic [ADDR_W-1:0]           dmaAddr,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memStrobe,
  output logic [NUM_CNT-1:0][CNT_W-1:0] counts
);
  always_comb begin
    memAddr = '0;
    if (strobe.selVid)      memAddr = vidAddr;
    else if (strobe.selDma) memAddr = dmaAddr;
    else if (strobe.selCpu) memAddr = cpuAddr;
  end

  assign memStrobe = strobe.selVid | strobe.selCpu | strobe.selDma;

  logic [NUM_CNT-1:0] incVec;
  assign incVec = {strobe.stall, strobe.selDma, strobe.selCpu, strobe.selVid};

  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cntQ <= '0;
      else if (incVec[i]) cntQ <= cntQ + CNT_W'(1);
    end
    assign counts[i] = cntQ;
  end
endmodule

// File: rtl/slotArbiter.sv
module slotArbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resync,
  input  logic              vidReq,
  input  logic [ADDR_W-1:0] vidAddr,
  output logic              vidGnt,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuGnt,
  output logic              cpuWait,
  input  logic              dmaReq,
  input  logic [ADDR_W-1:0] dmaAddr,
  output logic              dmaGnt,
  output logic              vidSlot,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memStrobe,
  output logic [CNT_W-1:0]  vidCount,
  output logic [CNT_W-1:0]  cpuCount,
  output logic [CNT_W-1:0]  dmaCount,
  output logic [CNT_W-1:0]  stallCount
);
  arbStrobe_t strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] counts;

  arbCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .resync (resync),
    .vidReq (vidReq),
    .cpuReq (cpuReq),
    .dmaReq (dmaReq),
    .vidSlot(vidSlot),
    .cpuWait(cpuWait),
    .strobe (strobe)
  );

  arbPath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .vidAddr  (vidAddr),
    .cpuAddr  (cpuAddr),
    .dmaAddr  (dmaAddr),
    .memAddr  (memAddr),
    .memStrobe(memStrobe),
    .counts   (counts)
  );

  assign vidGnt     = strobe.selVid;
  assign cpuGnt     = strobe.selCpu;
  assign dmaGnt     = strobe.selDma;
  assign vidCount   = counts[0];
  assign cpuCount   = counts[1];
  assign dmaCount   = counts[2];
  assign stallCount = counts[3];
endmodule

// File: rtl/slotArbiter_chk.sv
module slotArbiter_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              resync,
  input logic              vidReq,
  input logic [ADDR_W-1:0] vidAddr,
  input logic              vidGnt,
  input logic              cpuReq,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuGnt,
  input logic              cpuWait,
  input logic              dmaReq,
  input logic              dmaGnt,
  input logic              vidSlot,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memStrobe,
  input logic [CNT_W-1:0]  cpuCount,
  input logic [CNT_W-1:0]  stallCount
);
  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !resync |=> vidSlot != $past(vidSlot));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> vidSlot == $past(vidSlot));

  assert_vid_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vidSlot && vidReq) |-> (vidGnt && memStrobe && memAddr == vidAddr));

  assert_vid_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    vidSlot |-> (!cpuGnt && !dmaGnt));

  assert_dma_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!vidSlot && dmaReq) |-> (dmaGnt && (!cpuReq || cpuWait)));

  assert_realign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWait && vidSlot && !resync) |=> (!cpuReq || dmaReq || cpuGnt));

  assert_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuWait |-> (cpuReq && !cpuGnt));

  assert_cpu_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt |-> (memStrobe && memAddr == cpuAddr));

  assert_cpu_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt |=> cpuCount == $past(cpuCount) + CNT_W'(1));

  assert_stall_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuWait |=> stallCount == $past(stallCount) + CNT_W'(1));

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({vidGnt, cpuGnt, dmaGnt}));
endmodule

bind slotArbiter slotArbiter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .resync    (resync),
  .vidReq    (vidReq),
  .vidAddr   (vidAddr),
  .vidGnt    (vidGnt),
  .cpuReq    (cpuReq),
  .cpuAddr   (cpuAddr),
  .cpuGnt    (cpuGnt),
  .cpuWait   (cpuWait),
  .dmaReq    (dmaReq),
  .dmaGnt    (dmaGnt),
  .vidSlot   (vidSlot),
  .memAddr   (memAddr),
  .memStrobe (memStrobe),
  .cpuCount  (cpuCount),
  .stallCount(stallCount)
);

// File: tb/sim_slotArbiter.sv
module sim_slotArbiter;
  localparam int PERIOD = 10;
  localparam int AW = 12;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN, resync;
  logic vidReq, cpuReq, dmaReq;
  logic [AW-1:0] vidAddr, cpuAddr, dmaAddr;
  logic vidGnt, cpuGnt, cpuWait, dmaGnt, vidSlot, memStrobe;
  logic [AW-1:0] memAddr;
  logic [CW-1:0] vidCount, cpuCount, dmaCount, stallCount;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  slotArbiter #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .resync(resync),
    .vidReq(vidReq), .vidAddr(vidAddr), .vidGnt(vidGnt),
    .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuGnt(cpuGnt), .cpuWait(cpuWait),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .dmaGnt(dmaGnt),
    .vidSlot(vidSlot), .memAddr(memAddr), .memStrobe(memStrobe),
    .vidCount(vidCount), .cpuCount(cpuCount), .dmaCount(dmaCount),
    .stallCount(stallCount)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    #(PERIOD/2 - 1);
  endtask

  task automatic alignTo(input logic wantVideo);
    @(negedge clk);
    if (vidSlot !== wantVideo) @(negedge clk);
  endtask

  task automatic clearReqs();
    vidReq = 0; cpuReq = 0; dmaReq = 0; resync = 0;
  endtask

  task automatic testReset();
    rstN = 0; clearReqs();
    vidAddr = '0; cpuAddr = '0; dmaAddr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "vidSlot in reset", vidSlot, 1);
    chk("R1", "counters in reset", {vidCount, cpuCount} | {dmaCount, stallCount}, 0);
    chk("R8", "idle strobe in reset", memStrobe, 0);
    rstN = 1;
    settle();
    chk("R1", "first slot after reset", vidSlot, 1);
  endtask

  task automatic testAlternate();
    logic v0;
    @(negedge clk); v0 = vidSlot;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2", "toggle", vidSlot, !v0);
      v0 = vidSlot;
    end
    resync = 1;
    @(negedge clk); resync = 0;
    chk("R2", "hold after resync", vidSlot, v0);
    @(negedge clk);
    chk("R2", "toggle after hold", vidSlot, !v0);
  endtask

  task automatic testVideo();
    logic [CW-1:0] base;
    alignTo(1);
    base = vidCount;
    vidReq = 1; vidAddr = 12'h123;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      settle();
      if (k % 2 == 0) begin
        chk("R3", "video grant in video slot", vidGnt, 1);
        chk("R8", "video address", memAddr, 12'h123);
      end else begin
        chk("R3", "no video grant in free slot", vidGnt, 0);
        chk("R8", "idle strobe", memStrobe, 0);
      end
    end
    @(negedge clk); clearReqs();
    chk("R9", "video count", vidCount, base + 2);
  endtask

  task automatic testIdleVideoSlot();
    alignTo(1);
    cpuReq = 1; dmaReq = 1; cpuAddr = 12'h0f0; dmaAddr = 12'h0aa;
    settle();
    chk("R4", "cpu/dma grant in video slot", {cpuGnt, dmaGnt}, 0);
    chk("R4", "unused video slot idle", memStrobe, 0);
    chk("R8", "idle address", memAddr, 0);
    @(negedge clk); clearReqs();
  endtask

  task automatic testCpuStall();
    logic [CW-1:0] bStall, bCpu;
    alignTo(1);
    bStall = stallCount; bCpu = cpuCount;
    cpuReq = 1; cpuAddr = 12'h2a5;
    settle();
    chk("R6", "cpu held in video slot", cpuGnt, 0);
    chk("R7", "wait in video slot", cpuWait, 1);
    @(negedge clk); settle();
    chk("R6", "cpu granted after one wait", cpuGnt, 1);
    chk("R7", "wait dropped on grant", cpuWait, 0);
    chk("R8", "cpu address", memAddr, 12'h2a5);
    @(negedge clk); clearReqs();
    chk("R9", "stall count", stallCount, bStall + 1);
    chk("R9", "cpu count", cpuCount, bCpu + 1);
  endtask

  task automatic testDmaPriority();
    logic [CW-1:0] bDma, bStall;
    alignTo(0);
    bDma = dmaCount; bStall = stallCount;
    cpuReq = 1; dmaReq = 1; cpuAddr = 12'h111; dmaAddr = 12'h3c3;
    settle();
    chk("R5", "dma wins free slot", {dmaGnt, cpuGnt}, 2'b10);
    chk("R5", "cpu waits behind dma", cpuWait, 1);
    chk("R8", "dma address", memAddr, 12'h3c3);
    @(negedge clk); dmaReq = 0; settle();
    chk("R7", "cpu waits in video slot", cpuWait, 1);
    @(negedge clk); settle();
    chk("R5", "cpu granted next free slot", cpuGnt, 1);
    @(negedge clk); clearReqs();
    chk("R9", "dma count", dmaCount, bDma + 1);
    chk("R9", "stall count two waits", stallCount, bStall + 2);
  endtask

  task automatic testAligned();
    logic [CW-1:0] bStall;
    alignTo(0);
    bStall = stallCount;
    for (int i = 0; i < 3; i++) begin
      cpuReq = 1; cpuAddr = AW'(12'h400 + i);
      settle();
      chk("R11", "aligned cpu granted", {cpuGnt, cpuWait}, 2'b10);
      @(negedge clk); cpuReq = 0;
      @(negedge clk);
    end
    chk("R11", "no stall when aligned", stallCount, bStall);
  endtask

  task automatic testDrift();
    alignTo(0);
    resync = 1;
    @(negedge clk); resync = 0;
    @(negedge clk);
    cpuReq = 1; cpuAddr = 12'h5a5;
    settle();
    chk("R2", "drift moved cpu into video slot", vidSlot, 1);
    chk("R6", "cpu held after drift", cpuWait, 1);
    @(negedge clk); settle();
    chk("R6", "cpu realigned after drift", cpuGnt, 1);
    @(negedge clk); clearReqs();
  endtask

  task automatic testMixed();
    alignTo(1);
    vidReq = 1; cpuReq = 1; dmaReq = 1;
    vidAddr = 12'h010; cpuAddr = 12'h020; dmaAddr = 12'h030;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      settle();
      chk("R10", "single grant", $countones({vidGnt, cpuGnt, dmaGnt}), 1);
      chk("R10", "winner", {vidGnt, dmaGnt}, (k % 2 == 0) ? 2'b10 : 2'b01);
    end
    @(negedge clk); clearReqs();
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testAlternate();
    testVideo();
    testIdleVideoSlot();
    testCpuStall();
    testDmaPriority();
    testAligned();
    testDrift();
    testMixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule